// File: doc/BRIEF.md
# Calendar Shadow Register Synchronizer

This block stands between a slow calendar counter domain and a bus read port in the system clock domain. The counter domain provides its live sub-second, time and date words, and flips a toggle line each time those words advance. The block passes that toggle through a flop synchronizer. On the detected edge it copies all three words into shadow registers on one system clock edge. It then sets a ready flag, which tells software that the shadows hold a fresh and consistent snapshot.

Software can choose to read the live words instead of the shadows. In that mode a read costs one extra cycle and no wait on the ready flag is needed. A read of the sub-second shadow freezes the time and date shadows until the date shadow is read, so a three-word read stays coherent. An update that arrives during the freeze is held and applied when the date read releases it.

The block has two resets. The system reset clears the shadows, the flag and the read state. The synchronizer stays as it is, because the counters keep running. The power-on reset clears everything, the synchronizer included.

Top module: `cal_shadow_sync`

## Requirements
- R1: With `rst_n` low at a rising edge, the shadows and `rsf` read 0 afterwards, while the synchronizer keeps its state: no update occurs later unless `cnt_tgl` changes again, and bypass reads still return the live words.
- R2: With `por_n` low at a rising edge, the shadows, `rsf`, the read port and the synchronizer are all cleared. The counter domain holds `cnt_tgl` at 0 while power-on reset is applied.
- R3: After each change of `cnt_tgl`, all three shadows load from the live inputs on the third rising edge of `clk`, and `rsf` becomes 1 on that same edge. It is still 0 after the second edge.
- R4: When `low_pwr` is 1 at the load edge, the update is dropped and the shadows and `rsf` keep their values.
- R5: A pulse on `init_exit` or `shift_done`, or a write with `rsf_wr`=1 and `rsf_wdata`=0, clears `rsf` on that edge. A clear wins over an update on the same edge.
- R6: A write with `rsf_wr`=1 and `rsf_wdata`=1 leaves `rsf` unchanged.
- R7: With `byp_en`=0, a one-cycle `rd_req` gives `rd_ack`=1 in the cycle after the edge that samples it. `rd_data` is then the zero-extended shadow chosen by `rd_sel`: 0 for sub-second, 1 for time, 2 for date. The value 3 returns 0.
- R8: With `byp_en`=1, `rd_ack` comes one cycle later than for a shadow read. `rd_data` holds the live word sampled on the acknowledging edge, and the read has no freeze effect.
- R9: A shadow read of sub-second freezes the time and date shadows. Updates during the freeze load only the sub-second shadow. The next shadow read of date returns the frozen date and then loads time and date from the live inputs if an update was held.
- R10: A request that arrives while a bypass read is pending is ignored. The pending read completes with the data of its own selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| rst_n | input | 1 | System reset, active low, synchronous |
| cnt_tgl | input | 1 | Toggles on each counter advance (counter domain) |
| live_ss | input | SS_W | Live sub-second count |
| live_tm | input | TM_W | Live time word |
| live_dt | input | DT_W | Live date word |
| low_pwr | input | 1 | Low-power state, blocks shadow refresh |
| init_exit | input | 1 | Pulse on leaving initialization mode |
| shift_done | input | 1 | Pulse on a sub-second shift |
| byp_en | input | 1 | Read live words instead of shadows |
| rsf_wr | input | 1 | Write strobe for the ready flag |
| rsf_wdata | input | 1 | Written flag value (only 0 acts) |
| rd_req | input | 1 | One-cycle read request |
| rd_sel | input | 2 | Word select |
| rd_ack | output | 1 | Read acknowledge, one cycle |
| rd_data | output | BUS_W | Read data |
| rsf | output | 1 | Shadows synchronized flag |

## Verification
The assertions assume that the live words are stable from the `cnt_tgl` change through the load edge. They also assume that `rd_req` is a single-cycle pulse and that `cnt_tgl` is 0 whenever power-on reset is applied. The bench changes the live words and the toggle together on a falling edge and then waits at least three edges before the next change. It issues each request as an isolated pulse, except in the one directed case that exercises R10, and it drops the toggle during power-on reset. Random stimulus covers updates with and without low power, shadow and bypass reads of every selection, flag writes and shift pulses, in any order.

// File: rtl/cal_shadow_pkg.sv
// Package: word selection codes shared by the read port and the bench-visible rd_sel.
// Assumes: rd_sel is 2 bits; value 3 selects nothing and reads as zero.
package cal_shadow_pkg;
    typedef enum logic [1:0] {
        SEL_SUB  = 2'd0,
        SEL_TIME = 2'd1,
        SEL_DATE = 2'd2,
        SEL_NONE = 2'd3
    } word_sel_e;
endpackage

// File: rtl/cal_tgl_sync.sv
// Module: brings the counter-domain toggle into clk and emits a one-cycle update strobe.
// Assumes: cnt_tgl changes at most once per STAGES+1 clk cycles; reset only by power-on.
module cal_tgl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por_ni,
    input  logic tgl_i,
    output logic upd_o
);
    logic [STAGES-1:0] stg_q;
    logic              last_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Purpose: one synchronizer stage, fed by the input or the previous stage.
            always_ff @(posedge clk) begin
                if (!por_ni) stg_q[g] <= 1'b0;
                else if (g == 0) stg_q[g] <= tgl_i;
                else stg_q[g] <= stg_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    // Purpose: remember the last synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!por_ni) last_q <= 1'b0;
        else last_q <= stg_q[STAGES-1];
    end

    assign upd_o = stg_q[STAGES-1] ^ last_q;
endmodule

// File: rtl/cal_shadow_bank.sv
// Module: shadow sub-second/time/date registers, freeze logic and the synchronized flag.
// Assumes: live words stable while upd_i is high; rst_ni combines system and power-on reset.
module cal_shadow_bank #(
    parameter int SS_W = 16,
    parameter int TM_W = 22,
    parameter int DT_W = 24
) (
    input  logic            clk,
    input  logic            rst_ni,
    input  logic            upd_i,
    input  logic            lp_i,
    input  logic [SS_W-1:0] live_ss_i,
    input  logic [TM_W-1:0] live_tm_i,
    input  logic [DT_W-1:0] live_dt_i,
    input  logic            rd_ss_i,
    input  logic            rd_dt_i,
    input  logic            clr_i,
    output logic [SS_W-1:0] ss_o,
    output logic [TM_W-1:0] tm_o,
    output logic [DT_W-1:0] dt_o,
    output logic            rsf_o
);
    logic [SS_W-1:0] ss_q;
    logic [TM_W-1:0] tm_q;
    logic [DT_W-1:0] dt_q;
    logic            rsf_q, frz_q, pend_q;
    logic            load_ss, load_td, release_now;

    assign load_ss     = upd_i && !lp_i;
    assign release_now = rd_dt_i && frz_q;
    assign load_td     = (load_ss && !frz_q) || (release_now && pend_q);

    // Purpose: shadow word registers, loaded by updates or by release of a held update.
    always_ff @(posedge clk) begin
        if (!rst_ni) begin
            ss_q <= '0;
            tm_q <= '0;
            dt_q <= '0;
        end else begin
            if (load_ss) ss_q <= live_ss_i;
            if (load_td) begin
                tm_q <= live_tm_i;
                dt_q <= live_dt_i;
            end
        end
    end

    // Purpose: freeze on sub-second read, release on date read, remember held updates.
    always_ff @(posedge clk) begin
        if (!rst_ni) begin
            frz_q  <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            if (rd_dt_i) frz_q <= 1'b0;
            else if (rd_ss_i) frz_q <= 1'b1;
            if (release_now) pend_q <= 1'b0;
            else if (load_ss && frz_q) pend_q <= 1'b1;
        end
    end

    // Purpose: synchronized flag, clears take priority over a same-edge set.
    always_ff @(posedge clk) begin
        if (!rst_ni) rsf_q <= 1'b0;
        else if (clr_i) rsf_q <= 1'b0;
        else if (load_ss) rsf_q <= 1'b1;
    end

    assign ss_o  = ss_q;
    assign tm_o  = tm_q;
    assign dt_o  = dt_q;
    assign rsf_o = rsf_q;

    // R3
    rsf_set_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        (upd_i && !lp_i && !clr_i) |=> rsf_q);
    // R4
    lp_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        lp_i |=> $stable(ss_q));
    // R5
    rsf_clr_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        clr_i |=> !rsf_q);
    // R9
    frz_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        (frz_q && !rd_dt_i) |=> ($stable(tm_q) && $stable(dt_q)));
endmodule

// File: rtl/cal_read_port.sv
// Module: read port returning shadow words in one cycle or live words in two.
// Assumes: rd_req_i is a one-cycle pulse; requests during a pending bypass read are dropped.
module cal_read_port
    import cal_shadow_pkg::*;
#(
    parameter int BUS_W = 32,
    parameter int SS_W  = 16,
    parameter int TM_W  = 22,
    parameter int DT_W  = 24
) (
    input  logic             clk,
    input  logic             rst_ni,
    input  logic             rd_req_i,
    input  logic [1:0]       rd_sel_i,
    input  logic             byp_i,
    input  logic [SS_W-1:0]  sh_ss_i,
    input  logic [TM_W-1:0]  sh_tm_i,
    input  logic [DT_W-1:0]  sh_dt_i,
    input  logic [SS_W-1:0]  lv_ss_i,
    input  logic [TM_W-1:0]  lv_tm_i,
    input  logic [DT_W-1:0]  lv_dt_i,
    output logic             rd_ack_o,
    output logic [BUS_W-1:0] rd_data_o,
    output logic             rd_ss_o,
    output logic             rd_dt_o
);
    logic             busy_q, ack_q;
    logic [1:0]       sel_q;
    logic [BUS_W-1:0] data_q;
    logic             start;

    function automatic logic [BUS_W-1:0] pick(input logic [1:0] s,
                                              input logic [SS_W-1:0] a,
                                              input logic [TM_W-1:0] b,
                                              input logic [DT_W-1:0] c);
        case (word_sel_e'(s))
            SEL_SUB:  pick = {{(BUS_W-SS_W){1'b0}}, a};
            SEL_TIME: pick = {{(BUS_W-TM_W){1'b0}}, b};
            SEL_DATE: pick = {{(BUS_W-DT_W){1'b0}}, c};
            default:  pick = '0;
        endcase
    endfunction

    assign start   = rd_req_i && !busy_q;
    assign rd_ss_o = start && !byp_i && (word_sel_e'(rd_sel_i) == SEL_SUB);
    assign rd_dt_o = start && !byp_i && (word_sel_e'(rd_sel_i) == SEL_DATE);

    // Purpose: acknowledge sequencing and data capture for both read paths.
    always_ff @(posedge clk) begin
        if (!rst_ni) begin
            busy_q <= 1'b0;
            ack_q  <= 1'b0;
            sel_q  <= 2'd0;
            data_q <= '0;
        end else begin
            ack_q <= 1'b0;
            if (busy_q) begin
                ack_q  <= 1'b1;
                data_q <= pick(sel_q, lv_ss_i, lv_tm_i, lv_dt_i);
                busy_q <= 1'b0;
            end else if (start) begin
                if (byp_i) begin
                    busy_q <= 1'b1;
                    sel_q  <= rd_sel_i;
                end else begin
                    ack_q  <= 1'b1;
                    data_q <= pick(rd_sel_i, sh_ss_i, sh_tm_i, sh_dt_i);
                end
            end
        end
    end

    assign rd_ack_o  = ack_q;
    assign rd_data_o = data_q;

    // R7
    sh_ack_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        (rd_req_i && !byp_i && !busy_q) |=> rd_ack_o);
    // R8
    byp_ack_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        (rd_req_i && byp_i && !busy_q) |=> !rd_ack_o ##1 rd_ack_o);
    // R10
    byp_busy_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        busy_q |=> (rd_ack_o && !busy_q));
endmodule

// File: rtl/cal_shadow_sync.sv
// Module: top of the calendar shadow synchronizer; splits system and power-on reset.
// Assumes: live words move only together with cnt_tgl; cnt_tgl held 0 during power-on reset.
module cal_shadow_sync #(
    parameter int SS_W        = 16,
    parameter int TM_W        = 22,
    parameter int DT_W        = 24,
    parameter int BUS_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             rst_n,
    input  logic             cnt_tgl,
    input  logic [SS_W-1:0]  live_ss,
    input  logic [TM_W-1:0]  live_tm,
    input  logic [DT_W-1:0]  live_dt,
    input  logic             low_pwr,
    input  logic             init_exit,
    input  logic             shift_done,
    input  logic             byp_en,
    input  logic             rsf_wr,
    input  logic             rsf_wdata,
    input  logic             rd_req,
    input  logic [1:0]       rd_sel,
    output logic             rd_ack,
    output logic [BUS_W-1:0] rd_data,
    output logic             rsf
);
    logic            sys_rst_n, upd, clr, rd_ss, rd_dt;
    logic [SS_W-1:0] sh_ss;
    logic [TM_W-1:0] sh_tm;
    logic [DT_W-1:0] sh_dt;

    assign sys_rst_n = rst_n && por_n;
    assign clr       = init_exit || shift_done || (rsf_wr && !rsf_wdata);

    cal_tgl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .por_ni(por_n), .tgl_i(cnt_tgl), .upd_o(upd)
    );

    cal_shadow_bank #(.SS_W(SS_W), .TM_W(TM_W), .DT_W(DT_W)) u_bank (
        .clk(clk), .rst_ni(sys_rst_n), .upd_i(upd), .lp_i(low_pwr),
        .live_ss_i(live_ss), .live_tm_i(live_tm), .live_dt_i(live_dt),
        .rd_ss_i(rd_ss), .rd_dt_i(rd_dt), .clr_i(clr),
        .ss_o(sh_ss), .tm_o(sh_tm), .dt_o(sh_dt), .rsf_o(rsf)
    );

    cal_read_port #(.BUS_W(BUS_W), .SS_W(SS_W), .TM_W(TM_W), .DT_W(DT_W)) u_rd (
        .clk(clk), .rst_ni(sys_rst_n), .rd_req_i(rd_req), .rd_sel_i(rd_sel),
        .byp_i(byp_en), .sh_ss_i(sh_ss), .sh_tm_i(sh_tm), .sh_dt_i(sh_dt),
        .lv_ss_i(live_ss), .lv_tm_i(live_tm), .lv_dt_i(live_dt),
        .rd_ack_o(rd_ack), .rd_data_o(rd_data), .rd_ss_o(rd_ss), .rd_dt_o(rd_dt)
    );
endmodule

// File: tb/test_cal_shadow_sync.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random traffic against a bench-side model.
module test_cal_shadow_sync;
    logic        clk = 1'b0;
    logic        por_n, rst_n, cnt_tgl, low_pwr, init_exit, shift_done;
    logic        byp_en, rsf_wr, rsf_wdata, rd_req;
    logic [1:0]  rd_sel;
    logic [15:0] live_ss;
    logic [21:0] live_tm;
    logic [23:0] live_dt;
    logic        rd_ack, rsf;
    logic [31:0] rd_data;

    int n_chk = 0, n_fail = 0;
    logic [15:0] m_ss;
    logic [21:0] m_tm;
    logic [23:0] m_dt;
    bit m_rsf, m_frz, m_pend;

    cal_shadow_sync i_cal_shadow_sync (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .cnt_tgl(cnt_tgl),
        .live_ss(live_ss), .live_tm(live_tm), .live_dt(live_dt),
        .low_pwr(low_pwr), .init_exit(init_exit), .shift_done(shift_done),
        .byp_en(byp_en), .rsf_wr(rsf_wr), .rsf_wdata(rsf_wdata),
        .rd_req(rd_req), .rd_sel(rd_sel), .rd_ack(rd_ack), .rd_data(rd_data), .rsf(rsf)
    );

    always #10 clk = ~clk;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_word(input logic [1:0] s, input bit live);
        case (s)
            2'd0: model_word = live ? 32'(live_ss) : 32'(m_ss);
            2'd1: model_word = live ? 32'(live_tm) : 32'(m_tm);
            2'd2: model_word = live ? 32'(live_dt) : 32'(m_dt);
            default: model_word = 32'd0;
        endcase
    endfunction

    task automatic model_reset();
        m_ss = '0; m_tm = '0; m_dt = '0; m_rsf = 0; m_frz = 0; m_pend = 0;
    endtask

    // counter advance; clr_at_load pulses init_exit on the load edge
    task automatic tick(input logic [15:0] s, input logic [21:0] t, input logic [23:0] d,
                        input bit lp, input bit clr_at_load);
        @(negedge clk);
        live_ss = s; live_tm = t; live_dt = d; low_pwr = lp; cnt_tgl = ~cnt_tgl;
        @(negedge clk);
        @(negedge clk);
        if (clr_at_load) init_exit = 1'b1;
        @(negedge clk);
        init_exit = 1'b0; low_pwr = 1'b0;
        if (!lp) begin
            m_ss = s;
            if (m_frz) m_pend = 1; else begin m_tm = t; m_dt = d; end
            m_rsf = 1;
        end
        if (clr_at_load) m_rsf = 0;
    endtask

    task automatic rd_chk(input logic [1:0] s, input bit byp, input string tag);
        logic [31:0] exp;
        int lat;
        exp = model_word(s, byp);
        @(negedge clk);
        byp_en = byp; rd_sel = s; rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0; lat = 1;
        while (!rd_ack && lat < 6) begin @(negedge clk); lat++; end
        chk({tag, " data"}, rd_data, exp);
        chk({tag, " latency"}, 32'(lat), byp ? 32'd2 : 32'd1);
        if (!byp && s == 2'd0) m_frz = 1;
        if (!byp && s == 2'd2) begin
            if (m_frz && m_pend) begin m_tm = live_tm; m_dt = live_dt; end
            m_frz = 0; m_pend = 0;
        end
        byp_en = 1'b0;
    endtask

    task automatic flag_write(input bit v);
        @(negedge clk); rsf_wr = 1'b1; rsf_wdata = v;
        @(negedge clk); rsf_wr = 1'b0;
        if (!v) m_rsf = 0;
    endtask

    task automatic shift_pulse();
        @(negedge clk); shift_done = 1'b1;
        @(negedge clk); shift_done = 1'b0;
        m_rsf = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'd20240611));
        por_n = 0; rst_n = 0; cnt_tgl = 0; low_pwr = 0; init_exit = 0; shift_done = 0;
        byp_en = 0; rsf_wr = 0; rsf_wdata = 0; rd_req = 0; rd_sel = 0;
        live_ss = 16'h1111; live_tm = 22'h2222; live_dt = 24'h3333;
        model_reset();
        repeat (3) @(negedge clk);
        por_n = 1; rst_n = 1;
        repeat (4) @(negedge clk);
        // R2: power-on reset state, no spurious update
        chk("R2 rsf after por", 32'(rsf), 32'd0);
        rd_chk(2'd0, 0, "R2 ss after por");
        rd_chk(2'd1, 0, "R2 tm after por");
        rd_chk(2'd2, 0, "R2 dt after por");

        // R3: load timing on the third edge
        @(negedge clk);
        live_ss = 16'hA5A5; live_tm = 22'h12345; live_dt = 24'h654321; cnt_tgl = ~cnt_tgl;
        @(negedge clk); @(negedge clk);
        chk("R3 rsf before load edge", 32'(rsf), 32'd0);
        @(negedge clk);
        chk("R3 rsf at load edge", 32'(rsf), 32'd1);
        m_ss = live_ss; m_tm = live_tm; m_dt = live_dt; m_rsf = 1;
        rd_chk(2'd0, 0, "R3 ss shadow");
        rd_chk(2'd1, 0, "R3 tm shadow");
        rd_chk(2'd2, 0, "R3 dt shadow");
        // R7: unused selection
        rd_chk(2'd3, 0, "R7 sel3 zero");
        // R8: bypass latency and live data
        rd_chk(2'd1, 1, "R8 bypass tm");

        // R6 / R5: flag writes and clear events
        flag_write(1);
        chk("R6 write one keeps rsf", 32'(rsf), 32'd1);
        flag_write(0);
        chk("R5 write zero clears rsf", 32'(rsf), 32'd0);
        tick(16'h0001, 22'h1, 24'h1, 0, 0);
        @(negedge clk); init_exit = 1; @(negedge clk); init_exit = 0; m_rsf = 0;
        chk("R5 init exit clears rsf", 32'(rsf), 32'd0);
        tick(16'h0002, 22'h2, 24'h2, 0, 0);
        shift_pulse();
        chk("R5 shift clears rsf", 32'(rsf), 32'd0);
        tick(16'h0003, 22'h3, 24'h3, 0, 1);
        chk("R5 clear wins over update", 32'(rsf), 32'd0);
        rd_chk(2'd1, 0, "R5 shadow still loaded");

        // R4: low power blocks refresh
        tick(16'hBEEF, 22'h3BEEF, 24'hBEEF00, 1, 0);
        chk("R4 rsf stays clear", 32'(rsf), 32'd0);
        rd_chk(2'd0, 0, "R4 ss unchanged");
        rd_chk(2'd2, 0, "R4 dt unchanged (release)");

        // R9: freeze and held update
        tick(16'h0100, 22'h100, 24'h100, 0, 0);
        rd_chk(2'd0, 0, "R9 ss freezes");
        tick(16'h0200, 22'h200, 24'h200, 0, 0);
        rd_chk(2'd0, 0, "R9 ss updates in freeze");
        rd_chk(2'd1, 0, "R9 tm frozen");
        rd_chk(2'd1, 1, "R8 bypass during freeze");
        rd_chk(2'd2, 0, "R9 dt frozen");
        rd_chk(2'd1, 0, "R9 tm after release");
        rd_chk(2'd2, 0, "R9 dt after release");

        // R10: request during pending bypass read is dropped
        @(negedge clk);
        byp_en = 1; rd_sel = 2'd0; rd_req = 1;
        @(negedge clk);
        rd_sel = 2'd2;
        @(negedge clk);
        rd_req = 0;
        chk("R10 ack of first read", 32'(rd_ack), 32'd1);
        chk("R10 data of first read", rd_data, 32'(live_ss));
        @(negedge clk);
        chk("R10 no second ack", 32'(rd_ack), 32'd0);
        @(negedge clk);
        chk("R10 no late ack", 32'(rd_ack), 32'd0);
        byp_en = 0;

        // R1: system reset keeps synchronizer and live path
        tick(16'h0777, 22'h777, 24'h777, 0, 0);
        @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
        model_reset();
        chk("R1 rsf after sys reset", 32'(rsf), 32'd0);
        repeat (5) @(negedge clk);
        chk("R1 no spurious update", 32'(rsf), 32'd0);
        rd_chk(2'd0, 0, "R1 ss cleared");
        rd_chk(2'd2, 0, "R1 dt cleared");
        rd_chk(2'd0, 1, "R1 live kept");

        // random traffic
        for (int i = 0; i < 150; i++) begin
            r = $urandom % 8;
            if (r < 3) begin
                logic [31:0] a, b, c;
                a = $urandom; b = $urandom; c = $urandom;
                tick(a[15:0], b[21:0], c[23:0], ($urandom % 4) == 0, 0);
                chk("R3 random rsf", 32'(rsf), 32'(m_rsf));
            end else if (r < 6) begin
                logic [31:0] s;
                s = $urandom;
                rd_chk(s[1:0], s[2], "R7 random read");
            end else if (r == 6) begin
                flag_write($urandom % 2 == 1);
                chk("R6 random write", 32'(rsf), 32'(m_rsf));
            end else begin
                shift_pulse();
                chk("R5 random shift", 32'(rsf), 32'(m_rsf));
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule